// File: doc/BRIEF.md
# Bus Master Burst Request Controller

This block owns the request line of a bus master that fetches transmit buffers in bursts, and it chooses which read command each burst carries. The DMA logic signals that a burst is waiting; the block raises the request, waits for a grant while the bus is idle, and then runs exactly one burst in that bus tenure. It counts the completed data phases against the planned burst length and releases the bus only after the grant has gone away.

Two configuration bits shape each tenure. The hold bit selects between dropping the request as soon as the burst begins and keeping it up until the data phase before the last one has completed, for arbiters that do not preempt. The command bit selects the read command for transmit-buffer bursts. Both bits can be read at any time, can be written only while the controller is stopped or suspended, are cleared by the hard reset and survive the soft reset.

The controller has four states. IDLE waits for a pending burst (IDLE to REQ). REQ drives the request and waits for grant with the bus idle (REQ to BURST, called the start). BURST counts data phases; on the completion of the last phase it goes to RELEASE (BURST to RELEASE). RELEASE keeps the request low until the grant is removed (RELEASE to IDLE). The soft reset sends any state back to IDLE.

Top module: `pci_burst_req_ctl`

## Requirements
- R1: After the hard reset, req is 0, both configuration read-back bits are 0 and cmd is 4'hE.
- R2: In IDLE with xfer_pend at 1, req is 1 from the next clock edge on.
- R3: The burst starts at the first edge at which gnt and bus_idle are both 1 while req is up; gnt with bus_idle at 0 does not start it and req stays 1.
- R4: With the hold bit at 0, req is 0 from the edge at which the burst starts.
- R5: With the hold bit at 1, req stays 1 through the burst and falls at the edge at which the data phase before the last one completes (the completion of phase burst_len-1, counted by phase_done pulses).
- R6: A burst_len of 1 or 0 is a single data phase, and req is 0 from the start edge in both modes.
- R7: cmd is 4'hE (Memory Read Line) when the command bit is 0 and 4'hC (Memory Read Multiple) when it is 1; the value chosen at the start edge is held unchanged until the tenure ends, even if the bit is rewritten during the burst.
- R8: A configuration write (cfg_we) updates the two bits only while stopped or suspended is 1; otherwise it is ignored.
- R9: The soft reset returns the controller to IDLE with req at 0 and leaves both configuration bits unchanged.
- R10: After the last data phase completes, req stays 0 while gnt is 1, even with xfer_pend at 1; a new request is raised only after gnt has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, active low, asynchronous |
| srst | input | 1 | Soft reset, synchronous, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_hold_wd | input | 1 | Write data for the hold bit |
| cfg_multi_wd | input | 1 | Write data for the command bit |
| stopped | input | 1 | Controller stopped; opens configuration writes |
| suspended | input | 1 | Controller suspended; opens configuration writes |
| cfg_hold_rd | output | 1 | Read-back of the hold bit |
| cfg_multi_rd | output | 1 | Read-back of the command bit |
| xfer_pend | input | 1 | A burst is waiting in the DMA logic |
| gnt | input | 1 | Bus grant, active high |
| bus_idle | input | 1 | Bus has no transaction in progress |
| burst_len | input | LEN_W | Planned data phases of the burst, sampled at the start |
| phase_done | input | 1 | One data phase of the burst completed |
| req | output | 1 | Bus request, active high |
| cmd | output | 4 | Bus command code for the burst read |

## Verification
The bench builds the block with LEN_W = 4, which keeps the widest burst at 15 data phases, so a full-length burst in hold mode with the request falling after the fourteenth completion runs in a few dozen cycles. The same width makes a burst_len of 0 reachable, so the single-phase rule is covered for both 0 and 1 alongside a short burst in each mode.

// File: rtl/brq_pkg.sv
package brq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_REQ     = 2'd1,
        ST_BURST   = 2'd2,
        ST_RELEASE = 2'd3
    } brq_state_e;

    localparam logic [3:0] CMD_RD_LINE = 4'hE;
    localparam logic [3:0] CMD_RD_MULT = 4'hC;

endpackage

// File: rtl/brq_cfg.sv
module brq_cfg (
    input  logic clk,
    input  logic hrst_n,
    input  logic wr_en,
    input  logic wr_hold,
    input  logic wr_multi,
    input  logic stopped,
    input  logic suspended,
    output logic hold_q,
    output logic multi_q
);
    logic wr_open;

    assign wr_open = wr_en && (stopped || suspended);

    // Only the hard reset clears these bits (R8, R9).
    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            hold_q  <= 1'b0;
            multi_q <= 1'b0;
        end else if (wr_open) begin
            hold_q  <= wr_hold;
            multi_q <= wr_multi;
        end
    end

endmodule

// File: rtl/brq_phase_cnt.sv
module brq_phase_cnt #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             hrst_n,
    input  logic             srst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             dec,
    output logic [LEN_W-1:0] left_o,
    output logic             last_o,
    output logic             many_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    logic [LEN_W-1:0] left_q;
    logic [LEN_W-1:0] load_val;

    // A zero length is taken as a single phase (R6).
    assign load_val = (len == '0) ? ONE : len;

    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            left_q <= '0;
        end else if (srst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec) begin
            left_q <= left_q - ONE;
        end
    end

    assign left_o = left_q;
    assign last_o = (left_q == ONE);
    assign many_o = (left_q >= TWO);

endmodule

// File: rtl/brq_fsm.sv
module brq_fsm
    import brq_pkg::*;
(
    input  logic       clk,
    input  logic       hrst_n,
    input  logic       srst,
    input  logic       pend,
    input  logic       gnt,
    input  logic       bus_idle,
    input  logic       phase_done,
    input  logic       last,
    input  logic       many,
    input  logic       cfg_hold,
    input  logic       cfg_multi,
    output brq_state_e state_o,
    output logic       load_o,
    output logic       dec_o,
    output logic       req_o,
    output logic [3:0] cmd_o
);
    brq_state_e state_q;
    brq_state_e state_d;
    logic [3:0] cmd_lat_q;
    logic [3:0] cmd_sel;

    assign cmd_sel = cfg_multi ? CMD_RD_MULT : CMD_RD_LINE;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (pend)              state_d = ST_REQ;
            ST_REQ:     if (gnt && bus_idle)   state_d = ST_BURST;
            ST_BURST:   if (phase_done && last) state_d = ST_RELEASE;
            ST_RELEASE: if (!gnt)              state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
        if (srst) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Command chosen at the start edge is frozen for the tenure (R7).
    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            cmd_lat_q <= CMD_RD_LINE;
        end else if (load_o) begin
            cmd_lat_q <= cmd_sel;
        end
    end

    always_comb begin
        load_o = 1'b0;
        dec_o  = 1'b0;
        req_o  = 1'b0;
        cmd_o  = cmd_sel;
        unique case (state_q)
            ST_IDLE: begin
                req_o = 1'b0;
            end
            ST_REQ: begin
                req_o  = 1'b1;
                load_o = gnt && bus_idle && !srst;
            end
            ST_BURST: begin
                req_o = cfg_hold && many;
                dec_o = phase_done && !last && !srst;
                cmd_o = cmd_lat_q;
            end
            ST_RELEASE: begin
                req_o = 1'b0;
                cmd_o = cmd_lat_q;
            end
            default: begin
                req_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pci_burst_req_ctl.sv
module pci_burst_req_ctl
    import brq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             hrst_n,
    input  logic             srst,
    input  logic             cfg_we,
    input  logic             cfg_hold_wd,
    input  logic             cfg_multi_wd,
    input  logic             stopped,
    input  logic             suspended,
    output logic             cfg_hold_rd,
    output logic             cfg_multi_rd,
    input  logic             xfer_pend,
    input  logic             gnt,
    input  logic             bus_idle,
    input  logic [LEN_W-1:0] burst_len,
    input  logic             phase_done,
    output logic             req,
    output logic [3:0]       cmd
);
    brq_state_e       state_q;
    logic             ld;
    logic             dc;
    logic             lst;
    logic             mny;
    logic [LEN_W-1:0] left_q;

    brq_cfg u_cfg (
        .clk       (clk),
        .hrst_n    (hrst_n),
        .wr_en     (cfg_we),
        .wr_hold   (cfg_hold_wd),
        .wr_multi  (cfg_multi_wd),
        .stopped   (stopped),
        .suspended (suspended),
        .hold_q    (cfg_hold_rd),
        .multi_q   (cfg_multi_rd)
    );

    brq_phase_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk    (clk),
        .hrst_n (hrst_n),
        .srst   (srst),
        .load   (ld),
        .len    (burst_len),
        .dec    (dc),
        .left_o (left_q),
        .last_o (lst),
        .many_o (mny)
    );

    brq_fsm u_fsm (
        .clk        (clk),
        .hrst_n     (hrst_n),
        .srst       (srst),
        .pend       (xfer_pend),
        .gnt        (gnt),
        .bus_idle   (bus_idle),
        .phase_done (phase_done),
        .last       (lst),
        .many       (mny),
        .cfg_hold   (cfg_hold_rd),
        .cfg_multi  (cfg_multi_rd),
        .state_o    (state_q),
        .load_o     (ld),
        .dec_o      (dc),
        .req_o      (req),
        .cmd_o      (cmd)
    );

endmodule

// File: rtl/brq_checker.sv
module brq_checker
    import brq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             hrst_n,
    input logic             srst,
    input logic             gnt,
    input logic             bus_idle,
    input logic [LEN_W-1:0] burst_len,
    input logic             phase_done,
    input logic             stopped,
    input logic             suspended,
    input logic             req,
    input logic [3:0]       cmd,
    input logic             cfg_hold_rd,
    input logic             cfg_multi_rd,
    input brq_state_e       state_q
);
    p_cfg_lock_r8: assert property (@(posedge clk) disable iff (!hrst_n)
        (!stopped && !suspended) |=> ($stable(cfg_hold_rd) && $stable(cfg_multi_rd)));

    p_drop_at_start_r4: assert property (@(posedge clk) disable iff (!hrst_n)
        (state_q == ST_REQ && gnt && bus_idle && !srst && !cfg_hold_rd) |=> !req);

    p_single_phase_r6: assert property (@(posedge clk) disable iff (!hrst_n)
        (state_q == ST_REQ && gnt && bus_idle && !srst && burst_len <= LEN_W'(1)) |=> !req);

    p_hold_keeps_r5: assert property (@(posedge clk) disable iff (!hrst_n)
        (state_q == ST_BURST && req && !phase_done && !srst) |=> req);

    p_cmd_stable_r7: assert property (@(posedge clk) disable iff (!hrst_n)
        (state_q == ST_BURST && !srst) |=> $stable(cmd));

    p_cmd_code_r7: assert property (@(posedge clk) disable iff (!hrst_n)
        (cmd == CMD_RD_LINE) || (cmd == CMD_RD_MULT));

    p_no_rereq_r10: assert property (@(posedge clk) disable iff (!hrst_n)
        (state_q == ST_RELEASE) |-> !req);

    p_soft_reset_r9: assert property (@(posedge clk) disable iff (!hrst_n)
        srst |=> !req);

endmodule

bind pci_burst_req_ctl brq_checker #(.LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .hrst_n       (hrst_n),
    .srst         (srst),
    .gnt          (gnt),
    .bus_idle     (bus_idle),
    .burst_len    (burst_len),
    .phase_done   (phase_done),
    .stopped      (stopped),
    .suspended    (suspended),
    .req          (req),
    .cmd          (cmd),
    .cfg_hold_rd  (cfg_hold_rd),
    .cfg_multi_rd (cfg_multi_rd),
    .state_q      (state_q)
);

// File: tb/test_pci_burst_req_ctl.sv
module test_pci_burst_req_ctl;
    localparam int LEN_W = 4;
    localparam logic [3:0] E = 4'hE;
    localparam logic [3:0] C = 4'hC;

    logic             clk = 1'b0;
    logic             hrst_n, srst, cfg_we, cfg_hold_wd, cfg_multi_wd;
    logic             stopped, suspended, xfer_pend, gnt, bus_idle, phase_done;
    logic [LEN_W-1:0] burst_len;
    logic             cfg_hold_rd, cfg_multi_rd, req;
    logic [3:0]       cmd;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int         kind;   // 0 none, 1 req/cmd, 2 cfg, 3 both
        logic       r;
        logic [3:0] c;
        logic       h;
        logic       m;
        int         rq;
    } exp_t;

    exp_t sb[$];

    pci_burst_req_ctl #(.LEN_W(LEN_W)) i_pci_burst_req_ctl (
        .clk          (clk),
        .hrst_n       (hrst_n),
        .srst         (srst),
        .cfg_we       (cfg_we),
        .cfg_hold_wd  (cfg_hold_wd),
        .cfg_multi_wd (cfg_multi_wd),
        .stopped      (stopped),
        .suspended    (suspended),
        .cfg_hold_rd  (cfg_hold_rd),
        .cfg_multi_rd (cfg_multi_rd),
        .xfer_pend    (xfer_pend),
        .gnt          (gnt),
        .bus_idle     (bus_idle),
        .burst_len    (burst_len),
        .phase_done   (phase_done),
        .req          (req),
        .cmd          (cmd)
    );

    always #5 clk = ~clk;

    // Monitor: one expected item per clock edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            if (it.kind == 1 || it.kind == 3) begin
                checks++;
                if (req !== it.r || cmd !== it.c) begin
                    errors++;
                    $display("FAIL R%0d req/cmd actual %b/%h expected %b/%h",
                             it.rq, req, cmd, it.r, it.c);
                end
            end
            if (it.kind == 2 || it.kind == 3) begin
                checks++;
                if (cfg_hold_rd !== it.h || cfg_multi_rd !== it.m) begin
                    errors++;
                    $display("FAIL R%0d cfg actual %b%b expected %b%b",
                             it.rq, cfg_hold_rd, cfg_multi_rd, it.h, it.m);
                end
            end
        end
    end

    task automatic tick(input int kind, input logic r, input logic [3:0] c,
                        input logic h, input logic m, input int rq);
        exp_t it;
        it.kind = kind; it.r = r; it.c = c; it.h = h; it.m = m; it.rq = rq;
        sb.push_back(it);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        hrst_n = 0; srst = 0; cfg_we = 0; cfg_hold_wd = 0; cfg_multi_wd = 0;
        stopped = 0; suspended = 0; xfer_pend = 0; gnt = 0; bus_idle = 0;
        phase_done = 0; burst_len = '0;
        @(negedge clk);
        tick(3, 0, E, 0, 0, 1);             // R1 during reset
        hrst_n = 1;
        tick(3, 0, E, 0, 0, 1);             // R1 after release

        // Plain mode burst of four
        xfer_pend = 1;
        tick(1, 1, E, 0, 0, 2);             // R2 request raised
        gnt = 1; bus_idle = 0; burst_len = 4'd4;
        tick(1, 1, E, 0, 0, 3);             // R3 no start while bus busy
        bus_idle = 1;
        tick(1, 0, E, 0, 0, 4);             // R4 dropped at start
        xfer_pend = 0; bus_idle = 0; phase_done = 1;
        for (int i = 0; i < 3; i++) tick(1, 0, E, 0, 0, 4);
        tick(1, 0, E, 0, 0, 10);            // last phase -> release
        phase_done = 0; xfer_pend = 1;
        tick(1, 0, E, 0, 0, 10);            // R10 no re-request under grant
        gnt = 0; xfer_pend = 0;
        tick(1, 0, E, 0, 0, 10);
        tick(1, 0, E, 0, 0, 10);

        // Configuration writes
        cfg_we = 1; cfg_hold_wd = 1; cfg_multi_wd = 1;
        tick(2, 0, E, 0, 0, 8);             // R8 ignored when running
        suspended = 1;
        tick(3, 0, C, 1, 1, 8);             // R8 accepted, R7 code follows
        cfg_we = 0; suspended = 0;

        // Hold mode burst of three
        xfer_pend = 1;
        tick(1, 1, C, 0, 0, 2);
        gnt = 1; bus_idle = 1; burst_len = 4'd3;
        tick(1, 1, C, 0, 0, 5);             // R5 held at start
        xfer_pend = 0; bus_idle = 0;
        tick(1, 1, C, 0, 0, 5);             // no completion, still held
        phase_done = 1;
        tick(1, 1, C, 0, 0, 5);             // first completion
        cfg_we = 1; suspended = 1; cfg_hold_wd = 1; cfg_multi_wd = 0;
        tick(3, 0, C, 1, 0, 7);             // R5 falls, R7 cmd frozen
        cfg_we = 0; suspended = 0;
        tick(1, 0, C, 0, 0, 7);             // release, cmd still frozen
        phase_done = 0; gnt = 0;
        tick(1, 0, E, 0, 0, 7);             // idle, cmd follows bit again

        // Zero length in hold mode
        xfer_pend = 1;
        tick(1, 1, E, 0, 0, 2);
        gnt = 1; bus_idle = 1; burst_len = 4'd0;
        tick(1, 0, E, 0, 0, 6);             // R6 single phase
        xfer_pend = 0; bus_idle = 0; phase_done = 1;
        tick(1, 0, E, 0, 0, 6);
        phase_done = 0; gnt = 0;
        tick(1, 0, E, 0, 0, 6);

        // Length one in hold mode
        xfer_pend = 1;
        tick(1, 1, E, 0, 0, 2);
        gnt = 1; bus_idle = 1; burst_len = 4'd1;
        tick(1, 0, E, 0, 0, 6);             // R6 single phase
        xfer_pend = 0; bus_idle = 0; phase_done = 1;
        tick(1, 0, E, 0, 0, 6);
        phase_done = 0; gnt = 0;
        tick(1, 0, E, 0, 0, 6);

        // Longest burst in hold mode
        xfer_pend = 1;
        tick(1, 1, E, 0, 0, 2);
        gnt = 1; bus_idle = 1; burst_len = 4'd15;
        tick(1, 1, E, 0, 0, 5);
        xfer_pend = 0; bus_idle = 0; phase_done = 1;
        for (int i = 1; i <= 14; i++) tick(1, (i <= 13), E, 0, 0, 5);  // R5
        tick(1, 0, E, 0, 0, 10);
        phase_done = 0; gnt = 0;
        tick(1, 0, E, 0, 0, 10);

        // Soft reset while requesting
        xfer_pend = 1;
        tick(1, 1, E, 0, 0, 2);
        srst = 1; xfer_pend = 0;
        tick(3, 0, E, 1, 0, 9);             // R9
        srst = 0;
        tick(3, 0, E, 1, 0, 9);

        tick(0, 0, E, 0, 0, 0);
        finish_run();
    end

endmodule